// File: doc/BRIEF.md
# Condition-Code Register Load/Store Unit

This unit runs the word-sized instructions that move the 8-bit condition-code register (CCR) between the CPU and byte-addressed memory. A caller presents the complete instruction (the 0x0140 opcode word plus up to four following words) on a single 80-bit input and pulses `start` for one cycle.

In the cycle of `start`, the unit decodes the addressing form, reads one 32-bit pointer register through a combinational register-file read port, and forms a 24-bit effective address. It then performs exactly one byte access on a request/acknowledge memory port. For a load, it writes the byte it read into the CCR. For a store, it writes the CCR value that was present at `start`. For the auto-modify form, it also writes the updated pointer back to the register file.

An instruction that does not decode raises an error flag. An errored instruction changes nothing.

Top module: `ccr_xfer_unit`

## Requirements
- R1: `insn_i` carries word0 in bits [79:64], word1 in [63:48], word2 in [47:32], word3 in [31:16] and word4 in [15:0]. An instruction is accepted only if word0 is 0x0140 and word1[15:8] is one of 0x69, 0x6F, 0x78, 0x6D or 0x6B. Any other instruction makes `done` and `err` high together in the cycle after `start`.
- R2: Outside the 0x78 form, word1[7]=1 selects a store and word1[7]=0 selects a load. A store writes the CCR value sampled at `start` (`mem_we`=1). A load raises `ccr_wr_en` with the byte returned on the acknowledge.
- R3: Form 0x69 addresses memory at bits [23:0] of the register selected by word1[6:4].
- R4: Form 0x6F adds word2, sign-extended to 32 bits, to the pointer register. Bits [23:0] of the sum form the address.
- R5: In form 0x78, word2 must be 0x6BA0 (store) or 0x6B20 (load); any other value is an error. The address is the low 24 bits of the pointer register plus the 24-bit displacement held in word3[7:0]:word4.
- R6: In form 0x6D with word1[7]=1, the unit stores at pointer−2 and writes pointer−2 back to that register.
- R7: In form 0x6D with word1[7]=0, the unit loads at the current pointer and writes pointer+2 back to that register.
- R8: In form 0x6B, word1[7:0] selects the access:
  - 0x00: load, 16-bit address in word2.
  - 0x20: load, 24-bit address in word2[7:0]:word3.
  - 0x80: store, 16-bit address in word2.
  - 0xA0: store, 24-bit address in word2[7:0]:word3.
  - Any other value is an error.
- R9: A 16-bit absolute address with bit 15 set has address bits [23:16] forced to 0xFF. With bit 15 clear, those bits are 0x00.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is sampled high.
- R11: `done` rises for exactly one cycle, in the cycle after the acknowledge. `ccr_wr_en` and `rf_wr_en` are high only in that cycle.
- R12: An errored instruction issues no memory request and leaves both the CCR and the register file unchanged.
- R13: After reset, `done`, `err`, `mem_req`, `ccr_wr_en` and `rf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing `insn_i` (ignored while busy) |
| insn_i | input | 80 | Five instruction words, word0 in the top bits |
| ccr_i | input | 8 | Current CCR value |
| rf_rd_idx | output | 3 | Pointer register index for the read port |
| rf_rd_data | input | 32 | Pointer register value (combinational read) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Instruction rejected (with `done`) |
| ccr_wr_en | output | 1 | Load CCR from `ccr_wr_data` |
| ccr_wr_data | output | 8 | New CCR value |
| rf_wr_en | output | 1 | Write pointer register back |
| rf_wr_idx | output | 3 | Writeback register index |
| rf_wr_data | output | 32 | Updated pointer value |

## Verification
The bench builds the unit with its default widths: a 32-bit register file, 24-bit addresses and an 8-bit CCR.

It chooses pointer values that sit near 24-bit and 16-bit boundaries and carry nonzero upper bytes. This brings masking of the 32-bit sum, carries across bit 16, negative displacements and the 0xFF upper-byte extension within reach.

Acknowledge latencies from zero to three cycles exercise the request hold and the one-cycle-late completion pulse.

// File: rtl/ccr_xfer_pkg.sv
// Shared widths, state encoding and decoded-command type for the CCR
// load/store unit. Assumes a 32-bit register file and 24-bit byte addresses.
package ccr_xfer_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 24;
    localparam int CCR_W     = 8;
    localparam int IDX_W     = 3;
    localparam int WORD_W    = 16;
    localparam int NWORDS    = 5;
    localparam int INSN_W    = WORD_W * NWORDS;
    localparam int STEP      = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } xfer_state_e;

    typedef struct packed {
        logic              bad;
        logic              store;
        logic              wb_en;
        logic [IDX_W-1:0]  idx;
        logic [REG_W-1:0]  wb_val;
        logic [ADDR_W-1:0] addr;
    } xfer_cmd_t;
endpackage

// File: rtl/ccr_xfer_decode.sv
// Combinational decoder: splits the instruction into words, checks the
// opcode and addressing form, and forms the effective address and the
// pointer update. Assumes the pointer value arrives in the same cycle.
module ccr_xfer_decode
    import ccr_xfer_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [REG_W-1:0]  ptr_val,
    output logic [IDX_W-1:0]  ptr_idx,
    output xfer_cmd_t         cmd
);
    localparam logic [WORD_W-1:0] OPC      = 16'h0140;
    localparam logic [WORD_W-1:0] XLD_WORD = 16'h6B20;
    localparam logic [WORD_W-1:0] XST_WORD = 16'h6BA0;

    logic [WORD_W-1:0] w [NWORDS];
    logic [REG_W-1:0]  sum;

    // Slice the flat instruction into words, word0 first.
    generate
        for (genvar i = 0; i < NWORDS; i++) begin : g_word
            assign w[i] = insn[INSN_W-1-i*WORD_W -: WORD_W];
        end
    endgenerate

    assign ptr_idx = w[1][6:4];

    // Decode the form and compute address, direction and writeback.
    always_comb begin
        cmd        = '0;
        cmd.idx    = w[1][6:4];
        cmd.store  = w[1][7];
        sum        = ptr_val;
        unique case (w[1][15:8])
            8'h69: sum = ptr_val;
            8'h6F: sum = ptr_val + {{(REG_W-WORD_W){w[2][15]}}, w[2]};
            8'h78: begin
                sum       = ptr_val + {8'h00, w[3][7:0], w[4]};
                cmd.store = w[2][7];
                cmd.bad   = (w[2] != XLD_WORD) && (w[2] != XST_WORD);
            end
            8'h6D: begin
                cmd.wb_en = 1'b1;
                if (w[1][7]) begin
                    sum        = ptr_val - REG_W'(STEP);
                    cmd.wb_val = ptr_val - REG_W'(STEP);
                end else begin
                    sum        = ptr_val;
                    cmd.wb_val = ptr_val + REG_W'(STEP);
                end
            end
            8'h6B: begin
                unique case (w[1][7:0])
                    8'h00, 8'h80: sum = {{(REG_W-WORD_W){w[2][15]}}, w[2]};
                    8'h20, 8'hA0: sum = {8'h00, w[2][7:0], w[3]};
                    default:      cmd.bad = 1'b1;
                endcase
            end
            default: cmd.bad = 1'b1;
        endcase
        if (w[0] != OPC) cmd.bad = 1'b1;
        if (cmd.bad) begin
            cmd.wb_en  = 1'b0;
            cmd.wb_val = '0;
        end
        cmd.addr = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/ccr_xfer_seq.sv
// Transfer sequencer: latches a decoded command on start, holds one byte
// request until acknowledge, then emits a one-cycle done with the CCR and
// pointer writes. Assumes start is ignored while a transfer is in flight.
module ccr_xfer_seq
    import ccr_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_cmd_t         cmd,
    input  logic [CCR_W-1:0]  ccr_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CCR_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [CCR_W-1:0]  mem_rdata,
    output logic              done,
    output logic              err,
    output logic              ccr_wr_en,
    output logic [CCR_W-1:0]  ccr_wr_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [REG_W-1:0]  rf_wr_data
);
    xfer_state_e       state_q;
    xfer_cmd_t         cmd_q;
    logic [CCR_W-1:0]  wdata_q;
    logic [CCR_W-1:0]  rdata_q;

    // State, command latch and captured read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cmd_q   <= cmd;
                    wdata_q <= ccr_in;
                    state_q <= cmd.bad ? ST_ERR : ST_MEM;
                end
                ST_MEM: if (mem_ack) begin
                    rdata_q <= mem_rdata;
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the state and the latched command.
    always_comb begin
        mem_req     = (state_q == ST_MEM);
        mem_we      = cmd_q.store;
        mem_addr    = cmd_q.addr;
        mem_wdata   = wdata_q;
        done        = (state_q == ST_DONE) || (state_q == ST_ERR);
        err         = (state_q == ST_ERR);
        ccr_wr_en   = (state_q == ST_DONE) && !cmd_q.store;
        ccr_wr_data = rdata_q;
        rf_wr_en    = (state_q == ST_DONE) && cmd_q.wb_en;
        rf_wr_idx   = cmd_q.idx;
        rf_wr_data  = cmd_q.wb_val;
    end
endmodule

// File: rtl/ccr_xfer_unit.sv
// Top of the CCR load/store unit: joins the decoder to the register read
// port and to the sequencer. Assumes a combinational register-file read.
module ccr_xfer_unit
    import ccr_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [CCR_W-1:0]  ccr_i,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [REG_W-1:0]  rf_rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CCR_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [CCR_W-1:0]  mem_rdata,
    output logic              done,
    output logic              err,
    output logic              ccr_wr_en,
    output logic [CCR_W-1:0]  ccr_wr_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [REG_W-1:0]  rf_wr_data
);
    xfer_cmd_t dec_cmd;

    ccr_xfer_decode u_dec (
        .insn    (insn_i),
        .ptr_val (rf_rd_data),
        .ptr_idx (rf_rd_idx),
        .cmd     (dec_cmd)
    );

    ccr_xfer_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmd         (dec_cmd),
        .ccr_in      (ccr_i),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .done        (done),
        .err         (err),
        .ccr_wr_en   (ccr_wr_en),
        .ccr_wr_data (ccr_wr_data),
        .rf_wr_en    (rf_wr_en),
        .rf_wr_idx   (rf_wr_idx),
        .rf_wr_data  (rf_wr_data)
    );
endmodule

// File: rtl/ccr_xfer_chk.sv
// Protocol checker for the CCR load/store unit, bound to the top module.
// Assumes the synchronous active-low reset of the design.
module ccr_xfer_chk
    import ccr_xfer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CCR_W-1:0]  mem_wdata,
    input logic              mem_ack,
    input logic              done,
    input logic              err,
    input logic              ccr_wr_en,
    input logic              rf_wr_en
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> done && !err);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    write_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_wr_en || rf_wr_en) |-> done);

    // R12
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !mem_req && !ccr_wr_en && !rf_wr_en);

    // R1
    err_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(start));
endmodule

bind ccr_xfer_unit ccr_xfer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .done      (done),
    .err       (err),
    .ccr_wr_en (ccr_wr_en),
    .rf_wr_en  (rf_wr_en)
);

// File: tb/ccr_xfer_unit_bench.sv
// Self-checking bench: behavioural register file, CCR and memory responder,
// with a reference model predicting every transfer, compared each cycle.
module ccr_xfer_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] insn_i = '0;
    logic [7:0]  ccr_q = 8'h00;
    logic [2:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 8'h00;
    logic        done, err, ccr_wr_en, rf_wr_en;
    logic [7:0]  ccr_wr_data;
    logic [2:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;
    logic [31:0] regs [8];

    int checks = 0;
    int errors = 0;

    // Reference-model outputs
    bit          e_bad, e_st, e_wb;
    int unsigned e_addr, e_wbv, e_idx;

    always #10 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_idx];

    ccr_xfer_unit u_ccr_xfer_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .insn_i(insn_i), .ccr_i(ccr_q),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .err(err),
        .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
    );

    // Architectural state updated from the unit's write ports.
    always @(posedge clk) begin
        if (ccr_wr_en) ccr_q <= ccr_wr_data;
        if (rf_wr_en)  regs[rf_wr_idx] <= rf_wr_data;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: predicts the access from the requirement text.
    task automatic model(input logic [79:0] ins);
        int unsigned w0, w1, w2, w3, w4, p, hi, lo;
        longint s;
        w0 = ins[79:64]; w1 = ins[63:48]; w2 = ins[47:32]; w3 = ins[31:16]; w4 = ins[15:0];
        hi = w1 >> 8; lo = w1 & 'hFF;
        e_idx = (w1 >> 4) & 7;
        p = regs[e_idx];
        e_bad = 0; e_wb = 0; e_wbv = 0; e_st = (w1 >> 7) & 1;
        s = p;
        if (hi == 'h69) s = p;
        else if (hi == 'h6F) s = longint'(p) + ((w2 >= 'h8000) ? longint'(w2) - 65536 : longint'(w2));
        else if (hi == 'h78) begin
            e_st = (w2 == 'h6BA0);
            e_bad = (w2 != 'h6B20) && (w2 != 'h6BA0);
            s = longint'(p) + ((w3 & 'hFF) * 65536 + w4);
        end else if (hi == 'h6D) begin
            e_wb = 1;
            if (e_st) begin s = longint'(p) - 2; e_wbv = p - 2; end
            else begin s = p; e_wbv = p + 2; end
        end else if (hi == 'h6B) begin
            if (lo == 'h00 || lo == 'h80) s = (w2 >= 'h8000) ? ('hFF0000 | w2) : w2;
            else if (lo == 'h20 || lo == 'hA0) s = (w2 & 'hFF) * 65536 + w3;
            else e_bad = 1;
        end else e_bad = 1;
        if (w0 != 'h0140) e_bad = 1;
        if (e_bad) e_wb = 0;
        e_addr = int'(s & 'hFFFFFF);
    endtask

    // Run one instruction with an acknowledge after lat waiting cycles.
    task automatic run(input logic [79:0] ins, input int lat, input logic [7:0] rbyte, input string req);
        logic [7:0]  ccr0;
        logic [31:0] regs0 [8];
        model(ins);
        ccr0 = ccr_q;
        for (int i = 0; i < 8; i++) regs0[i] = regs[i];
        @(negedge clk); insn_i = ins; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (e_bad) begin
            chk(done && err, {req, " R1 err+done"}, {done, err}, 2'b11);
            chk(!mem_req && !ccr_wr_en && !rf_wr_en, {req, " R12 no side effect"},
                {mem_req, ccr_wr_en, rf_wr_en}, 0);
            @(negedge clk);
            chk(ccr_q == ccr0, {req, " R12 ccr kept"}, ccr_q, ccr0);
            for (int i = 0; i < 8; i++)
                chk(regs[i] == regs0[i], {req, " R12 reg kept"}, regs[i], regs0[i]);
            chk(!done, {req, " R11 done pulse"}, done, 0);
            return;
        end
        for (int c = 0; c <= lat; c++) begin
            chk(mem_req && !done, {req, " R10 request held"}, {mem_req, done}, 2'b10);
            chk(mem_addr == e_addr[23:0], {req, " address"}, mem_addr, e_addr);
            chk(mem_we == e_st, {req, " R2 direction"}, mem_we, e_st);
            if (e_st) chk(mem_wdata == ccr0, {req, " R2 store data"}, mem_wdata, ccr0);
            if (c == lat) begin mem_ack = 1'b1; mem_rdata = rbyte; end
            @(negedge clk);
            mem_ack = 1'b0;
        end
        chk(done && !err && !mem_req, {req, " R11 done after ack"}, {done, err, mem_req}, 3'b100);
        chk(ccr_wr_en == !e_st, {req, " R2 ccr write enable"}, ccr_wr_en, !e_st);
        chk(rf_wr_en == e_wb, {req, " R11 writeback enable"}, rf_wr_en, e_wb);
        @(negedge clk);
        chk(!done, {req, " R11 single pulse"}, done, 0);
        if (e_st) chk(ccr_q == ccr0, {req, " R2 ccr unchanged on store"}, ccr_q, ccr0);
        else      chk(ccr_q == rbyte, {req, " R2 ccr loaded"}, ccr_q, rbyte);
        if (e_wb) chk(regs[e_idx] == e_wbv, {req, " pointer update"}, regs[e_idx], e_wbv);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'h0;
        regs[2] = 32'h0000_1000;
        regs[3] = 32'h0012_3456;
        regs[5] = 32'hFF00_FFF0;
        ccr_q   = 8'h3C;
        repeat (3) @(negedge clk);
        chk(!done && !err && !mem_req && !ccr_wr_en && !rf_wr_en, "R13 reset state",
            {done, err, mem_req, ccr_wr_en, rf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req, "R13 idle after reset", {done, mem_req}, 0);

        run({16'h0140, 16'h6930, 48'h0}, 0, 8'hA5, "R3 indirect load");
        run({16'h0140, 16'h69D0, 48'h0}, 2, 8'h00, "R3 indirect store masked");
        run({16'h0140, 16'h6F20, 16'hFFF0, 32'h0}, 1, 8'h5A, "R4 negative disp load");
        run({16'h0140, 16'h6FD0, 16'h0020, 32'h0}, 3, 8'h00, "R4 positive disp store carry");
        run({16'h0140, 16'h7820, 16'h6B20, 32'hAB00_0100}, 1, 8'h81, "R5 disp24 load");
        run({16'h0140, 16'h7830, 16'h6BA0, 32'h00FF_FF00}, 0, 8'h00, "R5 disp24 store wrap");
        run({16'h0140, 16'h7820, 16'h6B40, 32'h0}, 0, 8'h00, "R5 bad second word");
        run({16'h0140, 16'h6DA0, 48'h0}, 1, 8'h00, "R6 predecrement store");
        run({16'h0140, 16'h6D20, 48'h0}, 2, 8'h77, "R7 postincrement load");
        run({16'h0140, 16'h6B00, 16'h8004, 32'h0}, 0, 8'h11, "R9 abs16 load high");
        run({16'h0140, 16'h6B00, 16'h1234, 32'h0}, 1, 8'h22, "R9 abs16 load low");
        run({16'h0140, 16'h6B20, 16'h55AB, 16'hCDEF, 16'h0}, 0, 8'h33, "R8 abs24 load");
        run({16'h0140, 16'h6B80, 16'h9000, 32'h0}, 2, 8'h00, "R8 abs16 store");
        run({16'h0140, 16'h6BA0, 16'h0001, 16'h2345, 16'h0}, 3, 8'h00, "R8 abs24 store");
        run({16'h0140, 16'h6B40, 48'h0}, 0, 8'h00, "R8 bad abs selector");
        run({16'h0150, 16'h6930, 48'h0}, 0, 8'h00, "R1 wrong opcode");
        run({16'h0140, 16'h7000, 48'h0}, 0, 8'h00, "R1 unknown form");
        run({16'h0140, 16'h6D30, 48'h0}, 0, 8'h0F, "R7 postincrement r3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule